// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a serial slave that lets a host controller read and write a bank of thirty-two 8-bit configuration registers. Every transfer opens with an instruction byte. That byte selects read or write, sets how many data bytes follow (one to four) and gives the first register address. The port then moves the data bytes, and it steps the address by itself after each byte. All port logic runs on the serial clock. Input bits are captured on the rising edge, and read bits are launched on the falling edge. Raising the active-low select at any point aborts the transfer and returns the port to the instruction phase.

Register 00h is the port's control register. Bit 7 picks the wire mode: 1 means read data leaves on the shared data line, and 0 means read data leaves on a separate output. Bit 6 picks the bit order: 1 is LSB first and 0 is MSB first. Bit 5 is a self-clearing soft reset. Each completed write also appears on a parallel notification (strobe, address, masked data) for one serial-clock period. The full register contents are available as a flat image for the logic being configured. The block has no back-pressure. A write notification is only a pulse and cannot be stalled. The host paces every transfer through the serial clock.

Top module: `spi_cfg_port`

## Requirements
- R1: The first eight captured bits form the instruction. Bit 7 = 1 means read and 0 means write. Bits 6:5 hold the byte count minus one (00 = one byte, 11 = four bytes). Bits 4:0 hold the start address.
- R2: Input bits are captured on rising SCLK edges. Each read bit is launched on the falling edge that precedes the rising edge on which the host samples it. The first read bit is launched on the falling edge right after the eighth instruction bit.
- R3: In MSB-first mode the address steps down by one after each byte and wraps from 00h to 1Fh. In LSB-first mode it steps up and wraps from 1Fh to 00h. LSB-first mode applies to the instruction byte as well as to the data bytes.
- R4: A written register takes its new value on the rising edge that captures the byte's last bit. wr_stb is high for exactly the following SCLK period, and during that period wr_addr and wr_data show the register and its stored value.
- R5: When cs_n goes high, both output enables drop at once and a partly shifted byte is discarded. The next transfer starts again with an instruction byte.
- R6: Bits clocked after the counted data bytes write nothing and leave both output enables low.
- R7: If 00h bit 7 = 1, read data appears on sdio_out with sdio_oe high, and sdo_oe stays low. If bit 7 = 0, read data appears on sdo_out with sdo_oe high, and sdio_oe stays low. The enables are high only in the data phase of a read while cs_n is low.
- R8: A write to 00h changes bit order and wire mode for the remaining bytes of the same transfer. The address step after a byte uses the mode that was in force while that byte was shifted.
- R9: Writing 00h with bit 5 = 1 returns registers 01h to 1Fh to their defaults. Register 00h takes the written value, and bit 5 reads back 0.
- R10: Reserved bits (00h bits 2:1, 1Fh bits 7:6) and 00h bit 5 always read 0, whatever is written to them.
- R11: Asserting rst_n low puts every register back to its default at once. The defaults are all zero except register 0Dh, which is 03h. Both output enables drop as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock from the host |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| cs_n | input | 1 | Chip select, active low |
| sdio_in | input | 1 | Received level of the shared data line |
| sdio_out | output | 1 | Read data for the shared data line |
| sdio_oe | output | 1 | Drive enable for the shared data line |
| sdo_out | output | 1 | Read data for the separate output line |
| sdo_oe | output | 1 | Drive enable for the separate output line |
| wr_stb | output | 1 | One-period pulse after each completed register write |
| wr_addr | output | 5 | Address of the register just written |
| wr_data | output | 8 | Value now stored in that register |
| reg_image | output | 256 | All registers, register n at bits 8n+7:8n |

## Verification
Results appear at three different points in time. Register contents and the write notification change on the rising edge that captures the eighth bit of a byte. The read bit and the output enables change on the following falling edge. Select and hardware reset act on the enables with no clock at all. The bench drives each bit just after a falling edge, and at that same moment it compares every output against a behavioural model. The model already reflects the previous rising edge and the falling edge just passed, so each comparison lands half a period away from any edge that could move the value. Select-release and reset results are read a short delay after the asynchronous event.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 5;
  localparam int CNT_W    = 2;
  localparam int NREG     = 1 << ADDR_W;
  localparam int BIT_W    = $clog2(BYTE_W);
  localparam int CTL_BIDIR = 7;
  localparam int CTL_LSB   = 6;
  localparam int CTL_SRST  = 5;

  typedef struct packed {
    logic              rd;
    logic [CNT_W-1:0]  cnt_m1;
    logic [ADDR_W-1:0] start;
  } instr_t;

  // writable bits of each register; reserved and self-clearing bits are 0
  function automatic logic [BYTE_W-1:0] wmask(int idx);
    if (idx == 0)        return 8'hD9;
    if (idx == NREG - 1) return 8'h3F;
    return 8'hFF;
  endfunction

  function automatic logic [BYTE_W-1:0] rdefault(int idx, int id_addr,
                                                 logic [BYTE_W-1:0] id_val);
    if (idx == id_addr) return id_val & wmask(idx);
    return '0;
  endfunction
endpackage

// File: rtl/spi_cfg_rx.sv
module spi_cfg_rx
  import spi_cfg_pkg::*;
(
  input  logic              sclk,
  input  logic              clr,
  input  logic              sdi,
  input  logic              lsb_first,
  output logic              wr_en,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic [BIT_W-1:0]  bit_idx,
  output logic              tx_phase
);
  logic [BIT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] sh;
  logic              in_data, is_rd, done;
  logic [CNT_W-1:0]  left;
  logic [ADDR_W-1:0] addr;
  logic [BYTE_W-1:0] nb;
  logic              last;
  instr_t            ins;

  assign nb   = lsb_first ? {sdi, sh} : {sh, sdi};
  assign last = (bit_cnt == BIT_W'(BYTE_W - 1));
  assign ins  = instr_t'(nb);

  always_ff @(posedge sclk or posedge clr) begin
    if (clr) begin
      bit_cnt <= '0;
      sh      <= '0;
      in_data <= 1'b0;
      is_rd   <= 1'b0;
      done    <= 1'b0;
      left    <= '0;
      addr    <= '0;
    end else if (!done) begin
      bit_cnt <= bit_cnt + BIT_W'(1);
      sh      <= lsb_first ? {sdi, sh[BYTE_W-2:1]} : {sh[BYTE_W-3:0], sdi};
      if (last) begin
        if (!in_data) begin
          in_data <= 1'b1;
          is_rd   <= ins.rd;
          left    <= ins.cnt_m1;
          addr    <= ins.start;
        end else begin
          if (left == '0) done <= 1'b1;
          else            left <= left - CNT_W'(1);
          addr <= lsb_first ? addr + ADDR_W'(1) : addr - ADDR_W'(1);
        end
      end
    end
  end

  assign wr_en    = in_data & ~is_rd & ~done & last;
  assign addr_o   = addr;
  assign byte_o   = nb;
  assign bit_idx  = bit_cnt;
  assign tx_phase = in_data & is_rd & ~done;
endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_cfg_pkg::*;
#(
  parameter int              ID_ADDR = 13,
  parameter logic [BYTE_W-1:0] ID_VAL = 8'h03
)(
  input  logic                   sclk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  logic [BYTE_W-1:0]      wr_data_i,
  output logic [NREG*BYTE_W-1:0] image,
  output logic                   stb,
  output logic [ADDR_W-1:0]      stb_addr,
  output logic [BYTE_W-1:0]      stb_data
);
  logic srst;
  assign srst = wr_en & (wr_addr_i == '0) & wr_data_i[CTL_SRST];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [BYTE_W-1:0] MASK = wmask(i);
    localparam logic [BYTE_W-1:0] DEF  = rdefault(i, ID_ADDR, ID_VAL);
    logic [BYTE_W-1:0] r;
    always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n)                                  r <= DEF;
      else if (wr_en && wr_addr_i == ADDR_W'(i))   r <= wr_data_i & MASK;
      else if (srst)                               r <= DEF;
    end
    assign image[i*BYTE_W +: BYTE_W] = r;
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      stb      <= 1'b0;
      stb_addr <= '0;
      stb_data <= '0;
    end else begin
      stb <= wr_en;
      if (wr_en) begin
        stb_addr <= wr_addr_i;
        stb_data <= wr_data_i & wmask(int'(wr_addr_i));
      end
    end
  end
endmodule

// File: rtl/spi_cfg_tx.sv
module spi_cfg_tx
  import spi_cfg_pkg::*;
(
  input  logic              sclk,
  input  logic              clr,
  input  logic              tx_phase,
  input  logic [BYTE_W-1:0] rd_byte,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic              lsb_first,
  input  logic              bidir,
  output logic              sdio_out,
  output logic              sdio_oe,
  output logic              sdo_out,
  output logic              sdo_oe
);
  logic             tx_bit, tx_act;
  logic [BIT_W-1:0] sel;

  assign sel = lsb_first ? bit_idx : BIT_W'(BYTE_W - 1) - bit_idx;

  always_ff @(negedge sclk or posedge clr) begin
    if (clr) begin
      tx_bit <= 1'b0;
      tx_act <= 1'b0;
    end else begin
      tx_bit <= rd_byte[sel];
      tx_act <= tx_phase;
    end
  end

  assign sdio_out = tx_bit;
  assign sdo_out  = tx_bit;
  assign sdio_oe  = tx_act & bidir & ~clr;
  assign sdo_oe   = tx_act & ~bidir & ~clr;
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
  import spi_cfg_pkg::*;
#(
  parameter int                ID_ADDR = 13,
  parameter logic [BYTE_W-1:0] ID_VAL  = 8'h03
)(
  input  logic                   sclk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   sdio_in,
  output logic                   sdio_out,
  output logic                   sdio_oe,
  output logic                   sdo_out,
  output logic                   sdo_oe,
  output logic                   wr_stb,
  output logic [ADDR_W-1:0]      wr_addr,
  output logic [BYTE_W-1:0]      wr_data,
  output logic [NREG*BYTE_W-1:0] reg_image
);
  logic              port_clr, wr_en, tx_phase, lsb_first, bidir;
  logic [ADDR_W-1:0] cur_addr;
  logic [BYTE_W-1:0] rx_byte, rd_byte;
  logic [BIT_W-1:0]  bit_idx;

  assign port_clr  = cs_n | ~rst_n;
  assign lsb_first = reg_image[CTL_LSB];
  assign bidir     = reg_image[CTL_BIDIR];
  assign rd_byte   = reg_image[{cur_addr, 3'b000} +: BYTE_W];

  spi_cfg_rx u_rx (
    .sclk(sclk), .clr(port_clr), .sdi(sdio_in), .lsb_first(lsb_first),
    .wr_en(wr_en), .addr_o(cur_addr), .byte_o(rx_byte), .bit_idx(bit_idx),
    .tx_phase(tx_phase)
  );

  spi_cfg_regs #(.ID_ADDR(ID_ADDR), .ID_VAL(ID_VAL)) u_regs (
    .sclk(sclk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr_i(cur_addr),
    .wr_data_i(rx_byte), .image(reg_image), .stb(wr_stb),
    .stb_addr(wr_addr), .stb_data(wr_data)
  );

  spi_cfg_tx u_tx (
    .sclk(sclk), .clr(port_clr), .tx_phase(tx_phase), .rd_byte(rd_byte),
    .bit_idx(bit_idx), .lsb_first(lsb_first), .bidir(bidir),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo_out(sdo_out), .sdo_oe(sdo_oe)
  );
endmodule

// File: rtl/spi_cfg_port_chk.sv
module spi_cfg_port_chk #(parameter int NREG = 32) (
  input logic            sclk,
  input logic            rst_n,
  input logic            cs_n,
  input logic            sdio_oe,
  input logic            sdo_oe,
  input logic            wr_stb,
  input logic [4:0]      wr_addr,
  input logic [7:0]      wr_data,
  input logic [NREG*8-1:0] reg_image
);
  a_r7_single_driver: assert property (@(negedge sclk) disable iff (!rst_n)
    !(sdio_oe && sdo_oe));

  a_r5_released_when_idle: assert property (@(negedge sclk) disable iff (!rst_n)
    cs_n |-> (!sdio_oe && !sdo_oe));

  a_r4_strobe_one_period: assert property (@(posedge sclk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  a_r4_image_matches_strobe: assert property (@(posedge sclk) disable iff (!rst_n)
    wr_stb |-> (reg_image[{wr_addr, 3'b000} +: 8] == wr_data));

  a_r10_reserved_zero: assert property (@(posedge sclk) disable iff (!rst_n)
    ((reg_image[7:0] & 8'h26) == 8'h00) && (reg_image[NREG*8-1 -: 2] == 2'b00));
endmodule

bind spi_cfg_port spi_cfg_port_chk #(.NREG(32)) u_chk (
  .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .sdio_oe(sdio_oe), .sdo_oe(sdo_oe),
  .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .reg_image(reg_image)
);

// File: tb/spi_cfg_port_test.sv
module spi_cfg_port_test;
  localparam int CLK_PERIOD = 20;

  logic         sclk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sdio_in = 1'b0;
  logic         sdio_out, sdio_oe, sdo_out, sdo_oe, wr_stb;
  logic [4:0]   wr_addr;
  logic [7:0]   wr_data;
  logic [255:0] reg_image;

  int n_chk = 0, n_bad = 0;
  logic [7:0] mreg [32];
  bit         exp_stb = 0;
  int         exp_waddr = 0;
  logic [7:0] exp_wdata = 0;
  bit         finished = 0;

  always #(CLK_PERIOD/2) sclk = ~sclk;

  spi_cfg_port uut (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo_out(sdo_out), .sdo_oe(sdo_oe),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .reg_image(reg_image)
  );

  function automatic logic [7:0] m_mask(int i);
    if (i == 0)  return 8'hD9;   // R10: 00h bits 5,2,1 read 0
    if (i == 31) return 8'h3F;   // R10: 1Fh bits 7:6 read 0
    return 8'hFF;
  endfunction

  function automatic logic [7:0] m_def(int i);
    return (i == 13) ? 8'h03 : 8'h00;  // R11 defaults
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) mreg[i] = m_def(i);
    exp_stb = 0;
  endtask

  task automatic model_write(int a, logic [7:0] d);
    mreg[a] = d & m_mask(a);
    if (a == 0 && d[5])
      for (int i = 1; i < 32; i++) mreg[i] = m_def(i);
    exp_stb = 1; exp_waddr = a; exp_wdata = d & m_mask(a);
  endtask

  task automatic expect_reg(int a, logic [7:0] v, string tag);
    check(reg_image[a*8 +: 8] == v, tag, $sformatf("reg %0h", a),
          int'(reg_image[a*8 +: 8]), int'(v));
  endtask

  task automatic compare_all(bit act, bit bitval);
    bit bidir;
    bidir = mreg[0][7];
    check(sdio_oe == (act & bidir), "R7", "sdio_oe", int'(sdio_oe), int'(act & bidir));
    check(sdo_oe == (act & ~bidir), "R7", "sdo_oe", int'(sdo_oe), int'(act & ~bidir));
    if (act) begin
      if (bidir) check(sdio_out == bitval, "R2", "sdio_out", int'(sdio_out), int'(bitval));
      else       check(sdo_out == bitval, "R2", "sdo_out", int'(sdo_out), int'(bitval));
    end
    check(wr_stb == exp_stb, "R4", "wr_stb", int'(wr_stb), int'(exp_stb));
    if (exp_stb) begin
      check(int'(wr_addr) == exp_waddr, "R4", "wr_addr", int'(wr_addr), exp_waddr);
      check(wr_data == exp_wdata, "R4", "wr_data", int'(wr_data), int'(exp_wdata));
    end
    for (int i = 0; i < 32; i++)
      if (reg_image[i*8 +: 8] !== mreg[i])
        check(0, "R4", $sformatf("image reg %0h", i), int'(reg_image[i*8 +: 8]), int'(mreg[i]));
    n_chk++;
    exp_stb = 0;
  endtask

  // nbits < 0: full transfer plus 'extra' trailing bits; else stop after nbits
  task automatic xfer(bit rd, int nbytes, int a0, logic [31:0] dat, int nbits, int extra);
    logic [7:0] instr, cur;
    int full, total, addr;
    bit lsb, bitval, act;
    instr = {rd, 2'(nbytes - 1), 5'(a0)};
    full  = 8 + 8 * nbytes;
    total = (nbits < 0) ? full + extra : nbits;
    addr  = a0;
    cur   = 0;
    for (int g = 0; g < total; g++) begin
      int b, j;
      b = 0; j = 0;
      @(negedge sclk); #1;
      cs_n = 1'b0;
      lsb = mreg[0][6];
      act = 0;
      if (g < 8) begin
        bitval = lsb ? instr[g] : instr[7-g];
      end else if (g < full) begin
        b = (g - 8) / 8; j = (g - 8) % 8;
        if (rd) begin
          if (j == 0) cur = mreg[addr];
          bitval = lsb ? cur[j] : cur[7-j];
          act = 1;
        end else begin
          bitval = lsb ? dat[b*8 + j] : dat[b*8 + 7 - j];
        end
      end else begin
        bitval = 1'b1;
      end
      sdio_in = (rd && g >= 8 && g < full) ? 1'b0 : bitval;
      compare_all(act, bitval);
      @(posedge sclk);
      if (g >= 8 && g < full && j == 7) begin
        if (!rd) model_write(addr, dat[b*8 +: 8]);
        addr = lsb ? (addr + 1) & 31 : (addr - 1) & 31;
      end
    end
    @(negedge sclk); #1;
    compare_all(0, 0);
    cs_n = 1'b1;
    #1;
    check(!sdio_oe && !sdo_oe, "R5", "enables after deselect",
          int'({sdio_oe, sdo_oe}), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      check(0, "WATCHDOG", "run did not finish", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge sclk);
    #1;
    // R11: reset state
    expect_reg(0, 8'h00, "R11");
    expect_reg(13, 8'h03, "R11");
    check(!sdio_oe && !sdo_oe, "R11", "enables in reset", int'({sdio_oe, sdo_oe}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge sclk);

    // R1 R4: single byte MSB-first write
    xfer(0, 1, 5, 32'h000000A5, -1, 0);
    expect_reg(5, 8'hA5, "R1");
    // R3: four bytes MSB-first, stepping down across 00h to 1Fh
    xfer(0, 4, 1, 32'h77660011, -1, 0);
    expect_reg(1, 8'h11, "R3");
    expect_reg(31, 8'h26, "R3");   // 66h masked by R10
    expect_reg(30, 8'h77, "R3");
    // R2 R7: four-wire read of 05h then 04h
    xfer(1, 2, 5, 0, -1, 0);
    // R7: switch to bidirectional and read three bytes
    xfer(0, 1, 0, 32'h00000080, -1, 0);
    xfer(1, 3, 1, 0, -1, 0);
    // R5: abort in the second byte; 08h written, 07h untouched
    xfer(0, 2, 8, 32'h00005A3C, 8 + 8 + 3, 0);
    expect_reg(8, 8'h3C, "R5");
    expect_reg(7, 8'h00, "R5");
    xfer(0, 1, 7, 32'h000000E1, -1, 0);
    expect_reg(7, 8'hE1, "R5");
    // R6: trailing bits after the count write nothing
    xfer(0, 1, 10, 32'h00000042, -1, 9);
    expect_reg(9, 8'h00, "R6");
    expect_reg(10, 8'h42, "R6");
    // R8: mode switch mid-transfer; step uses old order, next byte LSB-first
    xfer(0, 2, 0, 32'h0000FFC0, -1, 0);
    expect_reg(0, 8'hC0, "R8");
    expect_reg(31, 8'h3F, "R8");
    // R3: LSB-first stepping up across 1Fh to 00h
    xfer(0, 2, 31, 32'h0000C015, -1, 0);
    expect_reg(31, 8'h15, "R3");
    xfer(1, 2, 31, 0, -1, 0);
    xfer(1, 4, 4, 0, -1, 0);
    // R10: reserved bits of 00h; R9: soft reset
    xfer(0, 1, 0, 32'h000000A6, -1, 0);
    expect_reg(0, 8'h80, "R10");
    xfer(0, 1, 0, 32'h000000E0, -1, 0);
    expect_reg(0, 8'hC0, "R9");
    expect_reg(5, 8'h00, "R9");
    expect_reg(13, 8'h03, "R9");
    expect_reg(30, 8'h00, "R9");
    xfer(0, 1, 12, 32'h0000009C, -1, 0);
    xfer(1, 2, 12, 0, -1, 0);
    // R11: asynchronous hardware reset
    @(negedge sclk); #1;
    rst_n = 1'b0;
    #1;
    model_reset();
    expect_reg(12, 8'h00, "R11");
    expect_reg(0, 8'h00, "R11");
    @(negedge sclk); #1;
    rst_n = 1'b1;
    xfer(1, 1, 13, 0, -1, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule